// File: doc/BRIEF.md
# Global-history pattern-table branch direction predictor

This block guesses whether a conditional branch will be taken. It keeps a global shift register with the outcomes of recently resolved branches. It also keeps a table of 2-bit saturating counters. The table row is chosen by placing the history bits above a few low bits of the branch address. A lookup is purely combinational: the front end presents a fetch address, and in the same cycle it receives the guess, the table row that was used, and the history value at that moment. The history value serves as a checkpoint.

When the branch resolves, the back end sends back the row it was given and the real outcome. The block trains that counter and shifts the outcome into the history. If the branch was mispredicted, the back end also raises a flush with the saved checkpoint. The history is then rebuilt from that checkpoint plus the real outcome, instead of from the speculative value. The history length and the number of address bits are parameters. The table holds one counter for every combination of the two.

Top module: `bp_gsel_predictor`

## Requirements
- R1: The row index equals {history, pc[ADDR_W+1:2]}. The history bits occupy the upper part of the index. Address bits 1:0 are not used. The index is output on `lk_index`.
- R2: `lk_taken` is bit 1 of the selected counter. The value 1 means predict taken. The output follows `lk_pc` in the same cycle.
- R3: After reset, every counter holds 01, so every lookup predicts not taken. The history also reads all zeros after reset.
- R4: A resolved taken outcome adds one to the counter at `rs_index`. A counter already at 3 stays at 3.
- R5: A resolved not-taken outcome subtracts one from the counter at `rs_index`. A counter already at 0 stays at 0.
- R6: On each resolve without flush, the history shifts left by one bit. Bit 0 takes the outcome: 1 for taken, 0 for not taken. The oldest bit is dropped.
- R7: Training uses `rs_index` exactly as supplied, whatever the history holds at the time.
- R8: When a lookup and a resolve happen in the same cycle, the lookup sees the counter and history values from before the resolve. The new values appear from the next cycle.
- R9: A resolve with `rs_flush` high loads the history with {rs_ckpt[HIST_W-2:0], rs_taken}.
- R10: In a cycle with `rs_valid` low, no counter changes and the history holds its value. This applies whatever `rs_flush`, `rs_taken`, `rs_index` and `rs_ckpt` carry.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| lk_pc | input | PC_W | Address of the branch being looked up |
| lk_taken | output | 1 | Predicted direction, 1 means taken |
| lk_index | output | HIST_W+ADDR_W | Table row used for this lookup |
| lk_ckpt | output | HIST_W | Current global history, used as a checkpoint |
| rs_valid | input | 1 | A branch has resolved this cycle |
| rs_index | input | HIST_W+ADDR_W | Row that was returned at lookup time |
| rs_taken | input | 1 | Real outcome of the branch |
| rs_flush | input | 1 | Misprediction: rebuild the history from `rs_ckpt` |
| rs_ckpt | input | HIST_W | History checkpoint captured at lookup time |

## Verification
A lookup and a resolve can occur in the same cycle. The hard case is when both touch the same counter, and a flush may also rewrite the history at that moment. The bench brings this about in two ways. It resolves a branch in the same cycle it looks that branch up. It also mixes random flushes with a steady stream of same-row lookups. A behavioural model keeps the counters in an integer array and the history in an integer. The outputs are compared with the model before the model applies the resolve for that cycle, so a design that shows the updated value early is caught.

// File: rtl/bp_gsel_pkg.sv
package bp_gsel_pkg;

   typedef logic [1:0] ctr_t;

   localparam ctr_t CTR_INIT = 2'b01;
   localparam ctr_t CTR_MAX  = 2'b11;
   localparam ctr_t CTR_MIN  = 2'b00;

   // saturating step of a 2-bit direction counter
   function automatic ctr_t ctr_step(input ctr_t cur, input logic up);
      ctr_t nxt;
      if (up) nxt = (cur == CTR_MAX) ? cur : cur + 2'd1;
      else    nxt = (cur == CTR_MIN) ? cur : cur - 2'd1;
      return nxt;
   endfunction

endpackage

// File: rtl/bp_gsel_index.sv
module bp_gsel_index #(
   parameter int PC_W   = 32,
   parameter int HIST_W = 4,
   parameter int ADDR_W = 4,
   localparam int IDX_W = HIST_W + ADDR_W
) (
   input  logic [HIST_W-1:0] hist,
   input  logic [PC_W-1:0]   pc,
   output logic [IDX_W-1:0]  idx
);

   generate
      if (ADDR_W == 0) begin : g_hist_only
         assign idx = hist;
      end else begin : g_concat
         assign idx = {hist, pc[ADDR_W+1:2]};
      end
   endgenerate

   // bits outside the used slice are intentionally ignored
   logic unused_pc;
   assign unused_pc = ^pc;

endmodule

// File: rtl/bp_gsel_hist.sv
module bp_gsel_hist #(
   parameter int HIST_W = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              shift_en,
   input  logic              shift_bit,
   input  logic              load_en,
   input  logic [HIST_W-1:0] load_val,
   output logic [HIST_W-1:0] hist_q
);

   logic [HIST_W-1:0] base;
   logic [HIST_W-1:0] hist_d;

   always_comb begin
      base   = load_en ? load_val : hist_q;
      hist_d = {base[HIST_W-2:0], shift_bit};
   end

   always_ff @(posedge clk) begin
      if (!rst_n)        hist_q <= '0;
      else if (shift_en) hist_q <= hist_d;
   end

endmodule

// File: rtl/bp_gsel_pht.sv
module bp_gsel_pht
   import bp_gsel_pkg::*;
#(
   parameter int IDX_W = 8,
   localparam int DEPTH = 1 << IDX_W
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [IDX_W-1:0] rd_idx,
   output ctr_t             rd_ctr,
   input  logic             wr_en,
   input  logic [IDX_W-1:0] wr_idx,
   input  logic             wr_up
);

   ctr_t ent [DEPTH];

   generate
      for (genvar i = 0; i < DEPTH; i++) begin : g_ent
         ctr_t q;
         always_ff @(posedge clk) begin
            if (!rst_n)
               q <= CTR_INIT;
            else if (wr_en && (wr_idx == IDX_W'(i)))
               q <= ctr_step(q, wr_up);
         end
         assign ent[i] = q;
      end
   endgenerate

   assign rd_ctr = ent[rd_idx];

endmodule

// File: rtl/bp_gsel_predictor.sv
module bp_gsel_predictor
   import bp_gsel_pkg::*;
#(
   parameter int PC_W   = 32,
   parameter int HIST_W = 4,
   parameter int ADDR_W = 4,
   localparam int IDX_W = HIST_W + ADDR_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [PC_W-1:0]   lk_pc,
   output logic              lk_taken,
   output logic [IDX_W-1:0]  lk_index,
   output logic [HIST_W-1:0] lk_ckpt,
   input  logic              rs_valid,
   input  logic [IDX_W-1:0]  rs_index,
   input  logic              rs_taken,
   input  logic              rs_flush,
   input  logic [HIST_W-1:0] rs_ckpt
);

   generate
      if (HIST_W < 2) begin : g_bad_hist
         $error("HIST_W must be at least 2");
      end
      if (ADDR_W < 0 || ADDR_W + 2 > PC_W) begin : g_bad_addr
         $error("ADDR_W must fit inside PC_W above the two alignment bits");
      end
      if (IDX_W > 12) begin : g_bad_idx
         $error("table index too wide for a flop-based table");
      end
   endgenerate

   logic [HIST_W-1:0] hist_q;
   ctr_t              rd_ctr;

   bp_gsel_hist #(.HIST_W(HIST_W)) u_hist (
      .clk      (clk),
      .rst_n    (rst_n),
      .shift_en (rs_valid),
      .shift_bit(rs_taken),
      .load_en  (rs_flush),
      .load_val (rs_ckpt),
      .hist_q   (hist_q)
   );

   bp_gsel_index #(.PC_W(PC_W), .HIST_W(HIST_W), .ADDR_W(ADDR_W)) u_index (
      .hist(hist_q),
      .pc  (lk_pc),
      .idx (lk_index)
   );

   bp_gsel_pht #(.IDX_W(IDX_W)) u_pht (
      .clk   (clk),
      .rst_n (rst_n),
      .rd_idx(lk_index),
      .rd_ctr(rd_ctr),
      .wr_en (rs_valid),
      .wr_idx(rs_index),
      .wr_up (rs_taken)
   );

   assign lk_taken = rd_ctr[1];
   assign lk_ckpt  = hist_q;

endmodule

// File: rtl/bp_gsel_predictor_chk.sv
module bp_gsel_predictor_chk #(
   parameter int PC_W   = 32,
   parameter int HIST_W = 4,
   parameter int ADDR_W = 4,
   localparam int IDX_W = HIST_W + ADDR_W
) (
   input logic              clk,
   input logic              rst_n,
   input logic [PC_W-1:0]   lk_pc,
   input logic              lk_taken,
   input logic [HIST_W-1:0] lk_ckpt,
   input logic              rs_valid,
   input logic              rs_taken,
   input logic              rs_flush,
   input logic [HIST_W-1:0] rs_ckpt
);

   logic past_ok;
   always_ff @(posedge clk) past_ok <= rst_n;

   // R10: idle cycles leave the history alone
   p_hist_hold_r10: assert property (@(posedge clk) disable iff (!rst_n || !past_ok)
      !rs_valid |=> $stable(lk_ckpt));

   // R6: plain resolve shifts the outcome in at bit 0
   p_hist_shift_r6: assert property (@(posedge clk) disable iff (!rst_n || !past_ok)
      (rs_valid && !rs_flush) |=>
         lk_ckpt == {$past(lk_ckpt[HIST_W-2:0]), $past(rs_taken)});

   // R9: flush rebuilds from the checkpoint
   p_flush_restore_r9: assert property (@(posedge clk) disable iff (!rst_n || !past_ok)
      (rs_valid && rs_flush) |=>
         lk_ckpt == {$past(rs_ckpt[HIST_W-2:0]), $past(rs_taken)});

   // R10: with no resolve and a steady address the guess does not move
   p_pred_stable_r10: assert property (@(posedge clk) disable iff (!rst_n || !past_ok)
      (!rs_valid && $stable(lk_pc)) |=> (lk_taken == $past(lk_taken)) || !$stable(lk_pc));

   // R3: first cycle after reset shows a cleared history
   p_reset_hist_r3: assert property (@(posedge clk)
      (!rst_n) |=> lk_ckpt == '0);

endmodule

bind bp_gsel_predictor bp_gsel_predictor_chk #(
   .PC_W(PC_W), .HIST_W(HIST_W), .ADDR_W(ADDR_W)
) u_chk (
   .clk     (clk),
   .rst_n   (rst_n),
   .lk_pc   (lk_pc),
   .lk_taken(lk_taken),
   .lk_ckpt (lk_ckpt),
   .rs_valid(rs_valid),
   .rs_taken(rs_taken),
   .rs_flush(rs_flush),
   .rs_ckpt (rs_ckpt)
);

// File: tb/bp_gsel_predictor_tb.sv
module bp_gsel_predictor_tb;

   localparam int PC_W   = 32;
   localparam int HIST_W = 4;
   localparam int ADDR_W = 4;
   localparam int IDX_W  = HIST_W + ADDR_W;
   localparam int DEPTH  = 1 << IDX_W;
   localparam int HMASK  = (1 << HIST_W) - 1;

   logic              clk = 1'b0;
   logic              rst_n = 1'b0;
   logic [PC_W-1:0]   lk_pc = '0;
   logic              lk_taken;
   logic [IDX_W-1:0]  lk_index;
   logic [HIST_W-1:0] lk_ckpt;
   logic              rs_valid = 1'b0;
   logic [IDX_W-1:0]  rs_index = '0;
   logic              rs_taken = 1'b0;
   logic              rs_flush = 1'b0;
   logic [HIST_W-1:0] rs_ckpt = '0;

   always #5 clk = ~clk;

   bp_gsel_predictor #(.PC_W(PC_W), .HIST_W(HIST_W), .ADDR_W(ADDR_W)) u_dut (
      .clk(clk), .rst_n(rst_n), .lk_pc(lk_pc), .lk_taken(lk_taken),
      .lk_index(lk_index), .lk_ckpt(lk_ckpt), .rs_valid(rs_valid),
      .rs_index(rs_index), .rs_taken(rs_taken), .rs_flush(rs_flush),
      .rs_ckpt(rs_ckpt)
   );

   int    m_ctr [DEPTH];
   int    m_hist;
   int    n_chk = 0;
   int    n_fail = 0;
   bit    done = 1'b0;
   string tag = "R3";

   function automatic int m_index(input logic [PC_W-1:0] pc);
      return (m_hist << ADDR_W) | int'((pc >> 2) & ((1 << ADDR_W) - 1));
   endfunction

   task automatic check(input string what, input int act, input int exp);
      n_chk++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
      end
   endtask

   // compare the combinational outputs against the model, then advance one clock
   task automatic step();
      int idx;
      #2;
      idx = m_index(lk_pc);
      check("index", int'(lk_index), idx);
      check("taken", int'(lk_taken), (m_ctr[idx] >> 1) & 1);
      check("history", int'(lk_ckpt), m_hist);
      @(posedge clk);
      if (rs_valid) begin
         int c;
         c = m_ctr[rs_index];
         if (rs_taken) c = (c == 3) ? 3 : c + 1;
         else          c = (c == 0) ? 0 : c - 1;
         m_ctr[rs_index] = c;
         if (rs_flush) m_hist = ((int'(rs_ckpt) << 1) | int'(rs_taken)) & HMASK;
         else          m_hist = ((m_hist << 1) | int'(rs_taken)) & HMASK;
      end
      @(negedge clk);
   endtask

   task automatic drive(input logic [PC_W-1:0] pc, input logic v, input int idx,
                        input logic t, input logic f, input int ck);
      lk_pc    = pc;
      rs_valid = v;
      rs_index = IDX_W'(idx);
      rs_taken = t;
      rs_flush = f;
      rs_ckpt  = HIST_W'(ck);
      step();
   endtask

   initial begin
      #1_000_000;
      if (!done) begin
         n_fail++;
         $display("FAIL watchdog: actual hung expected finish");
         $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
         $finish;
      end
   end

   initial begin
      for (int i = 0; i < DEPTH; i++) m_ctr[i] = 1;
      m_hist = 0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;

      // R3: reset state across several addresses; R1 index layout
      tag = "R3";
      for (int i = 0; i < 6; i++) drive(32'h100 + 32'(i * 4), 0, 0, 0, 0, 0);
      tag = "R1";
      drive(32'h0000_003F, 0, 0, 0, 0, 0);
      drive(32'hFFFF_FFF3, 0, 0, 0, 0, 0);

      // R4: saturating increment at a fixed row, history kept out of the way by flush
      tag = "R4";
      for (int i = 0; i < 5; i++) drive(32'h24, 1, 9, 1, 1, 0);
      // R6: plain shifts of taken and not-taken outcomes
      tag = "R6";
      drive(32'h24, 1, 3, 1, 0, 0);
      drive(32'h24, 1, 3, 0, 0, 0);
      drive(32'h24, 1, 3, 1, 0, 0);
      drive(32'h24, 1, 3, 1, 0, 0);
      drive(32'h24, 1, 3, 0, 0, 0);
      // R5: saturating decrement
      tag = "R5";
      for (int i = 0; i < 5; i++) drive(32'h24, 1, 3, 0, 1, 0);

      // R10: idle resolve fields are ignored
      tag = "R10";
      for (int i = 0; i < 4; i++) drive(32'h24, 0, 9, 0, 1, 15);
      drive(32'h24, 0, 0, 1, 1, 7);

      // R7: train with a stale row after history moved on
      tag = "R7";
      drive(32'h8, 1, 200, 1, 1, 12);
      drive(32'h8, 1, 200, 1, 0, 0);
      drive(32'h8, 1, 200, 1, 1, 0);
      drive(32'h8, 0, 0, 0, 0, 0);

      // R8: lookup and resolve of the same row in one cycle
      tag = "R8";
      m_hist = m_hist; // model already tracks
      for (int i = 0; i < 4; i++) drive(32'h10, 1, m_index(32'h10), 1, 1, m_hist >> 1);
      for (int i = 0; i < 4; i++) drive(32'h10, 1, m_index(32'h10), 0, 1, m_hist >> 1);

      // R9: flush restores from checkpoints with varied contents
      tag = "R9";
      drive(32'h14, 1, 17, 1, 1, 10);
      drive(32'h14, 1, 18, 0, 1, 5);
      drive(32'h14, 1, 19, 1, 1, 15);

      // R2: random mix of lookups, resolves and flushes
      tag = "R2";
      for (int i = 0; i < 400; i++) begin
         logic [PC_W-1:0] pc;
         pc = 32'($urandom);
         drive(pc, 1'($urandom), ($urandom % 2) ? m_index(pc) : int'($urandom % DEPTH),
               1'($urandom), (($urandom % 5) == 0), int'($urandom % 16));
      end

      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

endmodule